// File: doc/BRIEF.md
# Shared Slave Port Arbiter

This block decides which of six bus masters may drive a single shared slave port. Each master raises a request and states the kind of burst it wants to run. A configuration input chooses between fixed-priority and round-robin selection. A separate policy input chooses where the grant rests when nobody is requesting: nowhere, on the master that last won through a request, or on a configured master. The grant is registered. It is presented both as a one-hot vector and as a binary index.

The slave paces the bus with a per-transfer `ready` strobe. The grant can only move on a transfer boundary, that is a cycle in which `ready` is high while the owner is requesting. A low `ready` is back-pressure: it freezes the current owner, whatever the other masters do. A grant that rests on a master without a request is not an ownership, so it gives way in any cycle, with or without `ready`.

A programmable slot limit bounds one ownership in clock cycles. This is the only thing that ends an open-ended burst while its master keeps requesting, and it also cuts a long fixed-length burst short. A limit of zero turns slot breaking off.

Top module: `shared_bus_arbiter`

## Requirements
- R1: In reset and in the first cycle after it, `gnt_o` is all zero and `gnt_idx_o` is 0. At every cycle at most one `gnt_o` bit is set. When a bit is set, `gnt_idx_o` holds its position.
- R2: With `cfg_rr_mode_i`=0, each master i has a 2-bit priority in `cfg_prio_i[2i+1:2i]`, and a larger value wins. Among requesters of equal priority, the lowest index wins.
- R3: With `cfg_rr_mode_i`=1, the search starts at the master after the last one granted through a request and wraps from 5 to 0. After reset the search starts at master 0.
- R4: While the owner (a master granted through a request) keeps requesting, the grant changes only at the clock edge that ends a cycle with `ready_i`=1. With no owner, or an owner whose request is low, a new choice is made at every edge whatever `ready_i` is.
- R5: Burst kind per master in `burst_i[2i+1:2i]`: 0 single, 1 four beats, 2 eight beats, 3 open-ended. The kind is taken when the grant is won. A single transfer is a boundary on each ready. A fixed burst keeps the grant until the ready of its last beat.
- R6: An open-ended burst keeps the grant for as long as its master requests, until the slot limit expires. Dropping the request gives the grant away at the next edge.
- R7: With `cfg_slot_lim_i`=L>0, the owner's cycle count restarts with every new choice. A choice is forced at the ready in cycle L of the ownership, so an owner with `ready_i` held high keeps the grant for exactly L cycles. L=0 disables this.
- R8: With policy 0 or 3 on `cfg_dflt_pol_i` and no requests, no grant is given at the next edge.
- R9: With policy 1 and no requests, the grant rests on the last master granted through a request (master 5 if there has been none since reset).
- R10: With policy 2 and no requests, the grant rests on `cfg_dflt_idx_i`. An index of 6 or more gives no grant. The default policies apply in both arbitration modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rr_mode_i | input | 1 | 0 fixed priority, 1 round robin |
| cfg_prio_i | input | 12 | Per-master 2-bit priority, master i at bits 2i+1:2i |
| cfg_dflt_pol_i | input | 2 | Idle policy: 0/3 none, 1 last, 2 fixed |
| cfg_dflt_idx_i | input | 3 | Master used by the fixed idle policy |
| cfg_slot_lim_i | input | 8 | Slot limit in cycles, 0 disables |
| req_i | input | 6 | Per-master request |
| burst_i | input | 12 | Per-master burst kind, master i at bits 2i+1:2i |
| ready_i | input | 1 | Transfer accepted by the slave |
| gnt_o | output | 6 | One-hot grant |
| gnt_idx_o | output | 3 | Index of the granted master |

## Verification
The arbitration is driven with dense request sets, so that every master competes, and with sparse ones, so that the round-robin wrap and the tie-breaking by index can be told apart from plain priority order. Ready is held low with a rival of higher priority waiting. This separates a boundary-gated rearbitration from one taken every cycle. Four-beat, eight-beat and open-ended bursts are run with and without a slot limit, which tells a burst that ends naturally from one that is broken. A master whose request rises while the grant merely rests on it shows whether a parked grant is wrongly treated as an ownership.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    BK_SINGLE = 2'd0,
    BK_FIX4   = 2'd1,
    BK_FIX8   = 2'd2,
    BK_OPEN   = 2'd3
  } burst_kind_e;

  typedef enum logic [1:0] {
    DP_NONE     = 2'd0,
    DP_LAST     = 2'd1,
    DP_FIXED    = 2'd2,
    DP_NONE_ALT = 2'd3
  } dflt_pol_e;

  localparam int unsigned BK_W = 2;
endpackage

// File: rtl/arb_prio_pick.sv
module arb_prio_pick #(
  parameter int unsigned N_MST  = 6,
  parameter int unsigned PRIO_W = 2,
  localparam int unsigned IDX_W = $clog2(N_MST)
) (
  input  logic [N_MST-1:0]        req_i,
  input  logic [N_MST*PRIO_W-1:0] prio_i,
  output logic                    found_o,
  output logic [IDX_W-1:0]        idx_o
);
  logic [PRIO_W-1:0] best;

  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    best    = '0;
    for (int i = 0; i < N_MST; i++) begin
      // strict compare: earlier (lower) index keeps ties
      if (req_i[i] && (!found_o || prio_i[i*PRIO_W +: PRIO_W] > best)) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
        best    = prio_i[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
  parameter int unsigned N_MST = 6,
  localparam int unsigned IDX_W = $clog2(N_MST)
) (
  input  logic [N_MST-1:0] req_i,
  input  logic [IDX_W-1:0] last_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  int cand;

  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    cand    = 0;
    for (int k = 1; k <= N_MST; k++) begin
      cand = int'(last_i) + k;
      if (cand >= N_MST) cand = cand - N_MST;
      if (!found_o && req_i[cand]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(cand);
      end
    end
  end
endmodule

// File: rtl/arb_tenure.sv
module arb_tenure
  import arb_pkg::*;
#(
  parameter int unsigned SLOT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  burst_kind_e       kind_i,
  input  logic              owner_req_i,
  input  logic              ready_i,
  input  logic [SLOT_W-1:0] limit_i,
  output logic              burst_last_o,
  output logic              slot_exp_o
);
  localparam int unsigned BEAT_W = 3;

  burst_kind_e       kind_q;
  logic [BEAT_W-1:0] beat_q;
  logic [SLOT_W-1:0] slot_q;

  always_comb begin
    unique case (kind_q)
      BK_SINGLE: burst_last_o = 1'b1;
      BK_FIX4:   burst_last_o = (beat_q == BEAT_W'(3));
      BK_FIX8:   burst_last_o = (beat_q == BEAT_W'(7));
      default:   burst_last_o = 1'b0;
    endcase
  end

  assign slot_exp_o = (limit_i != '0) && (slot_q >= (limit_i - SLOT_W'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= BK_SINGLE;
      beat_q <= '0;
      slot_q <= '0;
    end else if (start_i) begin
      kind_q <= kind_i;
      beat_q <= '0;
      slot_q <= '0;
    end else if (owner_req_i) begin
      if (slot_q != '1) slot_q <= slot_q + SLOT_W'(1);
      if (ready_i)      beat_q <= beat_q + BEAT_W'(1);
    end
  end
endmodule

// File: rtl/shared_bus_arbiter.sv
module shared_bus_arbiter
  import arb_pkg::*;
#(
  parameter int unsigned N_MST  = 6,
  parameter int unsigned PRIO_W = 2,
  parameter int unsigned SLOT_W = 8,
  localparam int unsigned IDX_W = $clog2(N_MST)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_rr_mode_i,
  input  logic [N_MST*PRIO_W-1:0] cfg_prio_i,
  input  logic [1:0]              cfg_dflt_pol_i,
  input  logic [IDX_W-1:0]        cfg_dflt_idx_i,
  input  logic [SLOT_W-1:0]       cfg_slot_lim_i,
  input  logic [N_MST-1:0]        req_i,
  input  logic [N_MST*BK_W-1:0]   burst_i,
  input  logic                    ready_i,
  output logic [N_MST-1:0]        gnt_o,
  output logic [IDX_W-1:0]        gnt_idx_o
);
  logic             gnt_vld_q, live_q;
  logic [IDX_W-1:0] gnt_idx_q, rr_last_q;

  logic             fx_found, rr_found;
  logic [IDX_W-1:0] fx_idx, rr_idx, win_idx;
  logic             owner_req, keep, any_req;
  logic             burst_last, slot_exp;
  logic             nxt_vld, nxt_live, start, upd_last;
  logic [IDX_W-1:0] nxt_idx;
  burst_kind_e      nxt_kind;

  arb_prio_pick #(.N_MST(N_MST), .PRIO_W(PRIO_W)) u_fx (
    .req_i(req_i), .prio_i(cfg_prio_i), .found_o(fx_found), .idx_o(fx_idx)
  );

  arb_rr_pick #(.N_MST(N_MST)) u_rr (
    .req_i(req_i), .last_i(rr_last_q), .found_o(rr_found), .idx_o(rr_idx)
  );

  arb_tenure #(.SLOT_W(SLOT_W)) u_ten (
    .clk(clk), .rst_n(rst_n), .start_i(start), .kind_i(nxt_kind),
    .owner_req_i(owner_req), .ready_i(ready_i), .limit_i(cfg_slot_lim_i),
    .burst_last_o(burst_last), .slot_exp_o(slot_exp)
  );

  assign any_req   = |req_i;
  assign win_idx   = cfg_rr_mode_i ? rr_idx : fx_idx;
  assign owner_req = gnt_vld_q && live_q && req_i[gnt_idx_q];
  assign keep      = owner_req && !(ready_i && (burst_last || slot_exp));

  always_comb begin
    nxt_vld  = 1'b0;
    nxt_live = 1'b0;
    nxt_idx  = '0;
    start    = 1'b1;
    upd_last = 1'b0;
    nxt_kind = BK_SINGLE;
    if (keep) begin
      nxt_vld  = 1'b1;
      nxt_live = 1'b1;
      nxt_idx  = gnt_idx_q;
      start    = 1'b0;
    end else if (any_req && (fx_found || rr_found)) begin
      nxt_vld  = 1'b1;
      nxt_live = 1'b1;
      nxt_idx  = win_idx;
      upd_last = 1'b1;
      nxt_kind = burst_kind_e'(burst_i[win_idx*BK_W +: BK_W]);
    end else begin
      unique case (dflt_pol_e'(cfg_dflt_pol_i))
        DP_LAST: begin
          nxt_vld = 1'b1;
          nxt_idx = rr_last_q;
        end
        DP_FIXED: begin
          if (int'(cfg_dflt_idx_i) < N_MST) begin
            nxt_vld = 1'b1;
            nxt_idx = cfg_dflt_idx_i;
          end
        end
        default: nxt_vld = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_vld_q <= 1'b0;
      live_q    <= 1'b0;
      gnt_idx_q <= '0;
      rr_last_q <= IDX_W'(N_MST - 1);
    end else begin
      gnt_vld_q <= nxt_vld;
      live_q    <= nxt_live;
      gnt_idx_q <= nxt_idx;
      if (upd_last) rr_last_q <= nxt_idx;
    end
  end

  for (genvar g = 0; g < N_MST; g++) begin : g_gnt
    assign gnt_o[g] = gnt_vld_q && (gnt_idx_q == IDX_W'(g));
  end

  assign gnt_idx_o = gnt_idx_q;
endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
  parameter int unsigned N_MST = 6,
  localparam int unsigned IDX_W = $clog2(N_MST)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_MST-1:0] req_i,
  input logic             ready_i,
  input logic [1:0]       pol_i,
  input logic [IDX_W-1:0] def_idx_i,
  input logic [N_MST-1:0] gnt_o,
  input logic             live_i
);
  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_o)); // R1

  AST_HOLD_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (live_i && ((gnt_o & req_i) != '0) && !ready_i) |=> $stable(gnt_o)); // R4

  AST_WINNER_REQUESTED: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_i != '0) && !(live_i && ((gnt_o & req_i) != '0))) |=> ((gnt_o & $past(req_i)) != '0)); // R4

  AST_IDLE_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_i == '0) && (pol_i == 2'd0 || pol_i == 2'd3)) |=> (gnt_o == '0)); // R8

  AST_IDLE_FIXED_PARK: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_i == '0) && (pol_i == 2'd2) && (int'(def_idx_i) < N_MST))
      |=> (gnt_o == (N_MST'(1) << $past(def_idx_i)))); // R10
endmodule

bind shared_bus_arbiter arb_checker #(.N_MST(N_MST)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .ready_i(ready_i),
  .pol_i(cfg_dflt_pol_i), .def_idx_i(cfg_dflt_idx_i), .gnt_o(gnt_o),
  .live_i(live_q)
);

// File: tb/tb_shared_bus_arbiter.sv
module tb_shared_bus_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int N = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rr_mode;
  logic [11:0] prio;
  logic [1:0]  pol;
  logic [2:0]  def_idx;
  logic [7:0]  slot_lim;
  logic [5:0]  req;
  logic [11:0] burst;
  logic        ready;
  logic [5:0]  gnt;
  logic [2:0]  gnt_idx;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    int       due;
    logic [5:0] exp;
    string    tag;
  } exp_t;
  exp_t sb[$];

  shared_bus_arbiter dut (
    .clk(clk), .rst_n(rst_n), .cfg_rr_mode_i(rr_mode), .cfg_prio_i(prio),
    .cfg_dflt_pol_i(pol), .cfg_dflt_idx_i(def_idx), .cfg_slot_lim_i(slot_lim),
    .req_i(req), .burst_i(burst), .ready_i(ready), .gnt_o(gnt), .gnt_idx_o(gnt_idx)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int pos_of(input logic [5:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return 0;
  endfunction

  task automatic compare(input logic [5:0] exp, input string tag);
    compared++;
    if (gnt !== exp || gnt_idx !== 3'(pos_of(exp))) begin
      mismatched++;
      $display("FAIL %s: gnt=%b idx=%0d expected gnt=%b idx=%0d",
               tag, gnt, gnt_idx, exp, pos_of(exp));
    end
  endtask

  // monitor: pops expected grants as they come due
  always @(negedge clk) begin
    exp_t e;
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      e = sb.pop_front();
      compare(e.exp, e.tag);
    end
  end

  // driver: inputs already set; expect result after the next edge
  task automatic step(input logic [5:0] exp, input string tag);
    exp_t e;
    e.due = cyc + 1;
    e.exp = exp;
    e.tag = tag;
    sb.push_back(e);
    @(posedge clk); #1;
  endtask

  task automatic set_prio(input int m, input logic [1:0] v);
    prio[m*2 +: 2] = v;
  endtask

  task automatic set_burst(input int m, input logic [1:0] v);
    burst[m*2 +: 2] = v;
  endtask

  task automatic do_reset();
    @(negedge clk); #1;
    rst_n = 1'b0;
    rr_mode = 1'b0; prio = '0; pol = 2'd0; def_idx = '0;
    slot_lim = '0; req = '0; burst = '0; ready = 1'b1;
    @(posedge clk); #1;
    compare(6'b000000, "R1 in reset");
    rst_n = 1'b1;
    @(posedge clk); #1;
  endtask

  initial begin
    rr_mode = 1'b0; prio = '0; pol = 2'd0; def_idx = '0;
    slot_lim = '0; req = '0; burst = '0; ready = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    compare(6'b000000, "R1 reset state");
    rst_n = 1'b1;
    @(posedge clk); #1;
    compare(6'b000000, "R1 after reset");

    // R2 fixed priority: ties go to lowest index, higher value wins
    do_reset();
    req = 6'b101100;
    step(6'b000100, "R2 tie lowest index");
    step(6'b000100, "R2 tie repeat");
    set_prio(5, 2'd3);
    step(6'b100000, "R2 higher priority wins");
    set_prio(3, 2'd3);
    step(6'b001000, "R2 equal top priority lowest index");

    // R4 ready low freezes the owner
    do_reset();
    req = 6'b100000;
    step(6'b100000, "R4 first grant");
    req = 6'b100001; ready = 1'b0;
    step(6'b100000, "R4 hold while ready low");
    step(6'b100000, "R4 hold while ready low 2");
    ready = 1'b1;
    step(6'b000001, "R4 rearbitrate on ready");

    // R3 round robin, dense and sparse
    do_reset();
    rr_mode = 1'b1; req = 6'b111111;
    for (int k = 0; k < 7; k++) step(6'(1 << (k % N)), "R3 dense rotation");
    do_reset();
    rr_mode = 1'b1; req = 6'b100100;
    step(6'b000100, "R3 sparse first");
    step(6'b100000, "R3 sparse next");
    step(6'b000100, "R3 sparse wrap");

    // R5 four-beat burst held to completion
    do_reset();
    rr_mode = 1'b1; set_burst(0, 2'd1); req = 6'b000011;
    for (int k = 0; k < 4; k++) step(6'b000001, "R5 four-beat hold");
    step(6'b000010, "R5 release after last beat");

    // R5 four-beat with a stalled beat
    do_reset();
    rr_mode = 1'b1; set_burst(0, 2'd1); req = 6'b000011;
    step(6'b000001, "R5 beat0");
    ready = 1'b0;
    step(6'b000001, "R5 stall");
    ready = 1'b1;
    for (int k = 0; k < 3; k++) step(6'b000001, "R5 stalled burst hold");
    step(6'b000010, "R5 stalled burst release");

    // R7 slot limit breaks an open-ended burst
    do_reset();
    rr_mode = 1'b1; set_burst(0, 2'd3); slot_lim = 8'd4; req = 6'b000011;
    for (int k = 0; k < 4; k++) step(6'b000001, "R7 open burst within slot");
    step(6'b000010, "R7 slot break");
    step(6'b000001, "R7 back to master 0");

    // R7 slot limit cuts a fixed eight-beat burst
    do_reset();
    rr_mode = 1'b1; set_burst(0, 2'd2); slot_lim = 8'd2; req = 6'b000011;
    step(6'b000001, "R7 eight-beat cycle 1");
    step(6'b000001, "R7 eight-beat cycle 2");
    step(6'b000010, "R7 eight-beat cut");

    // R6 / R7 limit zero: open burst held until request drops
    do_reset();
    rr_mode = 1'b1; set_burst(0, 2'd3); slot_lim = 8'd0; req = 6'b000011;
    for (int k = 0; k < 10; k++) step(6'b000001, "R6 open burst held, limit zero R7");
    req = 6'b000010;
    step(6'b000010, "R6 release on request drop");

    // R8 no default
    do_reset();
    pol = 2'd0;
    step(6'b000000, "R8 idle none");
    pol = 2'd3;
    step(6'b000000, "R8 idle none alt");

    // R10 fixed default, and out of range
    do_reset();
    pol = 2'd2; def_idx = 3'd4;
    step(6'b010000, "R10 park fixed");
    def_idx = 3'd7;
    step(6'b000000, "R10 out of range");

    // R9 last default, parked grant yields without ready
    do_reset();
    pol = 2'd1;
    step(6'b100000, "R9 park after reset");
    rr_mode = 1'b1; req = 6'b000100;
    step(6'b000100, "R9 grant 2");
    req = 6'b000000;
    step(6'b000100, "R9 park on last");
    req = 6'b001000; ready = 1'b0;
    step(6'b001000, "R4 parked yields without ready");
    req = 6'b001001;
    step(6'b001000, "R4 new owner held");
    ready = 1'b1;
    step(6'b000001, "R3 round robin after park");

    @(negedge clk); #1;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule